// File: doc/BRIEF.md
# Bus Ready and Processor Reset Synchroniser

This block produces the two control signals a processor takes from its clock generator: a bus-ready indication and a processor reset. The ready side takes two bus-ready requests. Each request is qualified by its own active-low enable, and the two qualified requests are ORed together. The result is retimed to the processor clock through either one stage or two stages, chosen by a mode input.

The reset side takes an active-low reset request and passes it through a two-flop synchroniser. It then holds `reset` high for a minimum number of clock cycles after the request has gone away. The output register updates on the falling edge of the processor clock.

The hold interacts with the oscillator restart sequence of a neighbouring stop/start controller. While that controller reports a restart count in progress, the hold counter is kept at zero. The minimum hold therefore only begins once the restart has finished, and a reset request never cuts a restart short.

Top module: `ready_reset_sync`

## Requirements
- R1: A bus-ready input counts only while its own enable is low (`busRdy0` with `busEn0N`, `busRdy1` with `busEn1N`). The qualified request is the OR of the two qualified inputs, so a high ready input whose enable is high has no effect on `ready`.
- R2: With `oneStage` high, `ready` takes the qualified request at the falling edge of `cpuClk`. An input applied after a rising edge is therefore visible on `ready` before the next rising edge.
- R3: With `oneStage` low, the qualified request is captured on the rising edge and forwarded to `ready` on the following falling edge. `ready` is then one clock cycle later than in one-stage mode.
- R4: While `rstReqN` is low, `ready` and the first ready stage are cleared at once, whatever the ready inputs do.
- R5: `rstReqN` low drives `reset` high without waiting for a clock edge, and `reset` stays high for as long as `rstReqN` stays low.
- R6: `reset` changes only on the falling edge of `cpuClk`. With `restartBusy` low, `reset` falls on the falling edge that follows the 18th rising edge to see `rstReqN` high. That is two synchroniser stages plus HOLD_CYCLES = 16 counted cycles.
- R7: While `restartBusy` is high and the hold is not complete, the hold counter stays at zero and `reset` stays high. After `restartBusy` returns low, `reset` falls on the falling edge that follows the 16th rising edge to see `restartBusy` low.
- R8: `restartBusy` has no effect once the hold has completed: `reset` stays low.
- R9: Pulling `rstReqN` low again during a hold restarts the full hold. The timing of R6 is then counted from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuClk | input | 1 | Processor clock; ready stage 1 and the hold counter use the rising edge, the outputs the falling edge |
| busRdy0 | input | 1 | Bus-ready request from the first source, active high |
| busRdy1 | input | 1 | Bus-ready request from the second source, active high |
| busEn0N | input | 1 | Active-low enable qualifying `busRdy0` |
| busEn1N | input | 1 | Active-low enable qualifying `busRdy1` |
| oneStage | input | 1 | 1 = one retiming stage on ready, 0 = two stages |
| rstReqN | input | 1 | Active-low reset request; also clears the ready path |
| restartBusy | input | 1 | High while the oscillator restart count of the stop controller is running |
| ready | output | 1 | Synchronised, qualified bus-ready to the processor |
| reset | output | 1 | Processor reset, active high, updated on the falling edge |

## Verification
The bound checker watches several properties on every rising edge:
- the ready latency in each synchroniser mode, checked against the qualified request;
- that `reset` is high whenever the request is low;
- that `reset` never falls while a restart is reported;
- that `reset` does not rise again without a new request;
- that every deassertion of `reset` comes at least HOLD_CYCLES cycles after release.

The exact cycle on which `reset` falls is shown only by the bench's directed scenarios. These cover a plain release, a restart that starts before the release, a restart that arrives mid-hold, a renewed request mid-hold, and a late restart that must be ignored. The OR of the two qualified sources under random enables and mode switching is also shown only by the bench.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  // Strobes from the hold control to the datapath.
  typedef struct packed {
    logic holdReq;   // synchronised reset request still active
    logic cntClear;  // force hold counter to zero
    logic cntStep;   // advance hold counter by one
  } holdStrobe_t;
endpackage

// File: rtl/rrs_hold_ctrl.sv
module rrs_hold_ctrl
  import rrs_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic        cpuClk,
  input  logic        rstReqN,
  input  logic        restartBusy,
  input  logic        holdDone,
  output holdStrobe_t strobe
);
  logic reqSeen;

  generate
    if (RST_SYNC_STAGES <= 1) begin : g_single
      logic syncQ;
      always_ff @(posedge cpuClk or negedge rstReqN) begin
        if (!rstReqN) syncQ <= 1'b0;
        else          syncQ <= 1'b1;
      end
      assign reqSeen = syncQ;
    end else begin : g_chain
      logic [RST_SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge cpuClk or negedge rstReqN) begin
        if (!rstReqN) syncQ <= '0;
        else          syncQ <= {syncQ[RST_SYNC_STAGES-2:0], 1'b1};
      end
      assign reqSeen = syncQ[RST_SYNC_STAGES-1];
    end
  endgenerate

  // Hold counting waits for any restart count in progress to finish.
  always_comb begin
    strobe.holdReq  = ~reqSeen;
    strobe.cntClear = ~reqSeen | (restartBusy & ~holdDone);
    strobe.cntStep  = reqSeen & ~restartBusy & ~holdDone;
  end
endmodule

// File: rtl/rrs_datapath.sv
module rrs_datapath
  import rrs_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic        cpuClk,
  input  logic        rstReqN,
  input  logic        busRdy0,
  input  logic        busRdy1,
  input  logic        busEn0N,
  input  logic        busEn1N,
  input  logic        oneStage,
  input  holdStrobe_t strobe,
  output logic        holdDone,
  output logic        ready,
  output logic        reset
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] holdCnt;
  logic qualReq;
  logic stageOne;
  logic readyQ;
  logic resetQ;

  // Hold counter, rising edge.
  always_ff @(posedge cpuClk or negedge rstReqN) begin
    if (!rstReqN)             holdCnt <= '0;
    else if (strobe.cntClear) holdCnt <= '0;
    else if (strobe.cntStep)  holdCnt <= holdCnt + 1'b1;
  end
  assign holdDone = (holdCnt == HOLD_VAL);

  // Qualified ready request from both sources.
  assign qualReq = (busRdy0 & ~busEn0N) | (busRdy1 & ~busEn1N);

  always_ff @(posedge cpuClk or negedge rstReqN) begin
    if (!rstReqN) stageOne <= 1'b0;
    else          stageOne <= qualReq;
  end

  always_ff @(negedge cpuClk or negedge rstReqN) begin
    if (!rstReqN) readyQ <= 1'b0;
    else          readyQ <= oneStage ? qualReq : stageOne;
  end

  // Reset output, falling edge, set at once by the request.
  always_ff @(negedge cpuClk or negedge rstReqN) begin
    if (!rstReqN) resetQ <= 1'b1;
    else          resetQ <= strobe.holdReq | ~holdDone;
  end

  assign ready = readyQ;
  assign reset = resetQ;
endmodule

// File: rtl/ready_reset_sync.sv
module ready_reset_sync
  import rrs_pkg::*;
#(
  parameter int HOLD_CYCLES     = 16,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic cpuClk,
  input  logic busRdy0,
  input  logic busRdy1,
  input  logic busEn0N,
  input  logic busEn1N,
  input  logic oneStage,
  input  logic rstReqN,
  input  logic restartBusy,
  output logic ready,
  output logic reset
);
  holdStrobe_t strobe;
  logic holdDone;

  rrs_hold_ctrl #(.RST_SYNC_STAGES(RST_SYNC_STAGES)) u_ctrl (
    .cpuClk     (cpuClk),
    .rstReqN    (rstReqN),
    .restartBusy(restartBusy),
    .holdDone   (holdDone),
    .strobe     (strobe)
  );

  rrs_datapath #(.HOLD_CYCLES(HOLD_CYCLES)) u_dp (
    .cpuClk  (cpuClk),
    .rstReqN (rstReqN),
    .busRdy0 (busRdy0),
    .busRdy1 (busRdy1),
    .busEn0N (busEn0N),
    .busEn1N (busEn1N),
    .oneStage(oneStage),
    .strobe  (strobe),
    .holdDone(holdDone),
    .ready   (ready),
    .reset   (reset)
  );
endmodule

// File: rtl/ready_reset_sync_chk.sv
module ready_reset_sync_chk #(
  parameter int HOLD_CYCLES = 16
) (
  input logic cpuClk,
  input logic busRdy0,
  input logic busRdy1,
  input logic busEn0N,
  input logic busEn1N,
  input logic oneStage,
  input logic rstReqN,
  input logic restartBusy,
  input logic ready,
  input logic reset
);
  logic reqQual;
  assign reqQual = (busRdy0 & ~busEn0N) | (busRdy1 & ~busEn1N);

  // Rising edges seen with request released and reset still high.
  int unsigned highRun;
  always_ff @(posedge cpuClk or negedge rstReqN) begin
    if (!rstReqN)   highRun <= 0;
    else if (reset) highRun <= highRun + 1;
  end

  // R2
  one_stage_chk: assert property (@(posedge cpuClk) disable iff (!rstReqN)
    oneStage |-> (ready == reqQual));

  // R3
  two_stage_chk: assert property (@(posedge cpuClk) disable iff (!rstReqN)
    (!oneStage && $past(rstReqN)) |-> (ready == $past(reqQual)));

  // R5
  req_sets_reset_chk: assert property (@(posedge cpuClk)
    !rstReqN |-> reset);

  // R7
  busy_keeps_reset_chk: assert property (@(posedge cpuClk) disable iff (!rstReqN)
    (reset && restartBusy) |=> reset);

  // R6
  hold_min_chk: assert property (@(posedge cpuClk) disable iff (!rstReqN)
    $fell(reset) |-> (highRun >= HOLD_CYCLES));

  // R8
  stays_low_chk: assert property (@(posedge cpuClk) disable iff (!rstReqN)
    !reset |=> !reset);
endmodule

bind ready_reset_sync ready_reset_sync_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .cpuClk     (cpuClk),
  .busRdy0    (busRdy0),
  .busRdy1    (busRdy1),
  .busEn0N    (busEn0N),
  .busEn1N    (busEn1N),
  .oneStage   (oneStage),
  .rstReqN    (rstReqN),
  .restartBusy(restartBusy),
  .ready      (ready),
  .reset      (reset)
);

// File: tb/sim_ready_reset_sync.sv
module sim_ready_reset_sync;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;

  logic cpuClk = 1'b0;
  always #(CLK_PERIOD/2) cpuClk = ~cpuClk;

  logic busRdy0 = 0, busRdy1 = 0, busEn0N = 1, busEn1N = 1;
  logic oneStage = 1, rstReqN = 1, restartBusy = 0;
  logic ready, reset;

  ready_reset_sync #(.HOLD_CYCLES(HOLD), .RST_SYNC_STAGES(2)) u0 (
    .cpuClk(cpuClk), .busRdy0(busRdy0), .busRdy1(busRdy1),
    .busEn0N(busEn0N), .busEn1N(busEn1N), .oneStage(oneStage),
    .rstReqN(rstReqN), .restartBusy(restartBusy),
    .ready(ready), .reset(reset));

  int checks = 0;
  int errors = 0;
  logic prevQual = 1'b0;
  logic expRdy = 1'b0;
  bit   summaryDone = 0;

  function automatic logic qualOf(logic r0, logic r1, logic e0n, logic e1n);
    return (r0 & ~e0n) | (r1 & ~e1n);
  endfunction

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: drive after the rising edge, sample just before the next.
  task automatic cyc(input logic r0, input logic r1, input logic e0n, input logic e1n,
                     input logic mode, input logic rstN, input logic busy);
    logic q;
    @(posedge cpuClk);
    #2;
    busRdy0 = r0; busRdy1 = r1; busEn0N = e0n; busEn1N = e1n;
    oneStage = mode; rstReqN = rstN; restartBusy = busy;
    #7;
    q = qualOf(r0, r1, e0n, e1n);
    expRdy = !rstN ? 1'b0 : (mode ? q : prevQual);
    prevQual = rstN ? q : 1'b0;
  endtask

  task automatic idle(input logic rstN, input logic busy);
    cyc(0, 0, 1, 1, 1, rstN, busy);
  endtask

  // Release request now; expect HOLD+1 further high samples, then low.
  task automatic releaseCheck(input string tag);
    idle(1, 0);
    check(reset === 1'b1, tag, reset, 1'b1);
    for (int j = 1; j <= HOLD + 2; j++) begin
      idle(1, 0);
      if (j <= HOLD + 1) check(reset === 1'b1, tag, reset, 1'b1);
      else               check(reset === 1'b0, tag, reset, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!summaryDone) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic r0, r1, e0n, e1n, md, rn;
    void'($urandom(32'd2025));
    #1 rstReqN = 1'b0;

    // R5 / R4: reset state
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, i[0], 0, 0);
    check(reset === 1'b1, "R5 reset high while request low", reset, 1'b1);
    check(ready === 1'b0, "R4 ready cleared while request low", ready, 1'b0);

    // R6: plain release
    releaseCheck("R6 hold after release");
    idle(1, 0);

    // R8: late restart has no effect
    for (int i = 0; i < 6; i++) begin
      idle(1, 1);
      check(reset === 1'b0, "R8 restart after hold", reset, 1'b0);
    end
    idle(1, 0);

    // R7: restart in progress at release
    idle(0, 1); idle(0, 1);
    for (int i = 0; i < 8; i++) begin
      idle(1, 1);
      check(reset === 1'b1, "R7 held during restart", reset, 1'b1);
    end
    for (int j = 0; j <= HOLD; j++) begin
      idle(1, 0);
      if (j < HOLD) check(reset === 1'b1, "R7 hold after restart", reset, 1'b1);
      else          check(reset === 1'b0, "R7 hold after restart", reset, 1'b0);
    end

    // R7: restart arriving mid-hold
    idle(0, 0);
    for (int i = 0; i < 8; i++) idle(1, 0);
    for (int i = 0; i < 3; i++) begin
      idle(1, 1);
      check(reset === 1'b1, "R7 mid-hold restart", reset, 1'b1);
    end
    for (int j = 0; j <= HOLD; j++) begin
      idle(1, 0);
      if (j < HOLD) check(reset === 1'b1, "R7 mid-hold resume", reset, 1'b1);
      else          check(reset === 1'b0, "R7 mid-hold resume", reset, 1'b0);
    end

    // R9: renewed request mid-hold restarts the full hold
    idle(0, 0);
    for (int i = 0; i < 10; i++) idle(1, 0);
    idle(0, 0);
    check(reset === 1'b1, "R9 renewed request", reset, 1'b1);
    releaseCheck("R9 full hold after renewed request");

    // R1: directed qualification corner cases, two-stage mode
    cyc(1, 0, 1, 0, 0, 1, 0); cyc(1, 0, 1, 0, 0, 1, 0);
    check(ready === 1'b0, "R1 disabled source 0 ignored", ready, 1'b0);
    cyc(0, 1, 0, 1, 0, 1, 0); cyc(0, 1, 0, 1, 0, 1, 0);
    check(ready === 1'b0, "R1 disabled source 1 ignored", ready, 1'b0);
    cyc(0, 1, 1, 0, 0, 1, 0); cyc(0, 1, 1, 0, 0, 1, 0);
    check(ready === 1'b1, "R1 source 1 qualified", ready, 1'b1);
    cyc(1, 0, 0, 0, 1, 1, 0);
    check(ready === 1'b1, "R1 source 0 qualified", ready, 1'b1);

    // R2 / R3: latency edge in each mode
    cyc(0, 0, 0, 0, 1, 1, 0);
    check(ready === 1'b0, "R2 one-stage same cycle", ready, 1'b0);
    cyc(1, 1, 0, 0, 0, 1, 0);
    check(ready === 1'b0, "R3 two-stage one cycle late", ready, 1'b0);
    cyc(1, 1, 0, 0, 0, 1, 0);
    check(ready === 1'b1, "R3 two-stage arrives", ready, 1'b1);

    // Random ready traffic with occasional reset requests (R1 R2 R3 R4)
    for (int n = 0; n < 400; n++) begin
      r0 = 1'($urandom); r1 = 1'($urandom);
      e0n = 1'($urandom); e1n = 1'($urandom);
      md = 1'($urandom);
      rn = ($urandom_range(0, 29) != 0);
      cyc(r0, r1, e0n, e1n, md, rn, 0);
      if (!rn)      check(ready === expRdy, "R4 random ready cleared", ready, expRdy);
      else if (md)  check(ready === expRdy, "R2 random one-stage", ready, expRdy);
      else          check(ready === expRdy, "R3 random two-stage", ready, expRdy);
    end

    summaryDone = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule